// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block chooses which of several interrupt request lines is serviced next. Each line has a pending bit, an enable bit and an 8-bit priority value. A numerically smaller value is more urgent. A line can win only when it is both pending and enabled. The winner is the qualifying line with the smallest priority value. If two lines tie, the lower index wins.

A 3-bit split control `grp_split` sets how the priority is divided. The upper bits are the group part, and the low `grp_split` bits are the subpriority. Only the group part decides whether the winner may interrupt the handler that is running now. Only the top `IMPL_BITS` bits of each priority are stored. The bits below them are treated as zero everywhere. The arbitration logic is combinational, and its three results are registered once per clock.

Top module: `irq_group_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, `win_idx`, `win_valid` and `win_preempt` become 0 after that edge.
- R2: Only a line whose `req_pend` and `req_en` bits are both 1 can win. `win_valid` is 0 when no line qualifies.
- R3: Among qualifying lines, the winner has the smallest group part. The group part is the masked priority shifted right by `grp_split`.
- R4: When qualifying lines share the smallest group part, the one with the smallest subpriority wins. The subpriority is the masked priority bits below bit `grp_split`.
- R5: When both group part and subpriority are equal, the lowest line index wins.
- R6: Only priority bits [7:8-IMPL_BITS] take part. With the default IMPL_BITS=4 these are bits [7:4]. Lines whose priorities differ only in lower bits compare as equal.
- R7: With `hdl_active`=1, `win_preempt` is 1 only when the winner's group part is strictly less than the group part of `hdl_prio`, masked and shifted the same way. An equal group part gives 0.
- R8: With `hdl_active`=0 (thread level), `win_preempt` equals `win_valid`.
- R9: The outputs reflect the inputs sampled at the previous rising edge. There is exactly one register stage.
- R10: `grp_split`=0 makes the whole priority the group part. `grp_split`=7 leaves a 1-bit group part (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | NUM_LINES | Pending bit per line |
| req_en | input | NUM_LINES | Enable bit per line |
| req_prio | input | 8*NUM_LINES | Priority of line i in bits [8i+7:8i] |
| grp_split | input | 3 | Number of low subpriority bits |
| hdl_active | input | 1 | A handler is currently running |
| hdl_prio | input | 8 | Priority of the running handler |
| win_idx | output | $clog2(NUM_LINES) | Index of the selected line |
| win_valid | output | 1 | A line qualified |
| win_preempt | output | 1 | The winner may interrupt the running handler |

## Verification
Selection by subpriority and the preemption decision fall in the same cycle. This is the case where the winner is picked among lines of equal group only by subpriority, while its group part equals the active handler's group part. The bench sets this up directly. It places two lines in one group with different subpriorities, makes `hdl_prio` share that group, and then repeats the case under other `grp_split` values. It then checks that the lower-subpriority line is reported but `win_preempt` stays 0. Random patterns compare all three outputs against a bench model built from the requirements.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;

  // mask keeping only the implemented upper bits
  function automatic prio_t impl_mask(input int impl_bits);
    return ~((prio_t'(1) << (PRIO_W - impl_bits)) - prio_t'(1));
  endfunction

  function automatic prio_t group_part(input prio_t p, input logic [2:0] split);
    return p >> split;
  endfunction
endpackage

// File: rtl/irq_line_qual.sv
module irq_line_qual
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IMPL_BITS = 4
) (
  input  logic [NUM_LINES-1:0]        pend,
  input  logic [NUM_LINES-1:0]        en,
  input  logic [PRIO_W*NUM_LINES-1:0] prio_flat,
  output logic [NUM_LINES-1:0]        qual,
  output logic [PRIO_W*NUM_LINES-1:0] mprio_flat
);
  localparam prio_t MASK = impl_mask(IMPL_BITS);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign qual[i] = pend[i] & en[i];
    assign mprio_flat[PRIO_W*i +: PRIO_W] = prio_flat[PRIO_W*i +: PRIO_W] & MASK;
  end
endmodule

// File: rtl/irq_pick_min.sv
module irq_pick_min
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]        qual,
  input  logic [PRIO_W*NUM_LINES-1:0] mprio_flat,
  output logic                        found,
  output logic [IDX_W-1:0]            best_idx,
  output prio_t                       best_prio
);
  // Group sits above subpriority, so the smallest masked value gives
  // the smallest group first, then the smallest subpriority.
  // Strict "<" keeps the lowest index on a full tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (qual[i] && (!found || (mprio_flat[PRIO_W*i +: PRIO_W] < best_prio))) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = mprio_flat[PRIO_W*i +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_preempt_gate.sv
module irq_preempt_gate
  import irq_arb_pkg::*;
#(
  parameter int IMPL_BITS = 4
) (
  input  logic       found,
  input  prio_t      best_prio,
  input  logic [2:0] split,
  input  logic       active,
  input  prio_t      active_prio,
  output logic       preempt
);
  localparam prio_t MASK = impl_mask(IMPL_BITS);
  prio_t win_grp, act_grp;

  always_comb begin
    win_grp = group_part(best_prio, split);
    act_grp = group_part(active_prio & MASK, split);
    preempt = found && (!active || (win_grp < act_grp));
  end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IMPL_BITS = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        req_pend,
  input  logic [NUM_LINES-1:0]        req_en,
  input  logic [PRIO_W*NUM_LINES-1:0] req_prio,
  input  logic [2:0]                  grp_split,
  input  logic                        hdl_active,
  input  logic [PRIO_W-1:0]           hdl_prio,
  output logic [IDX_W-1:0]            win_idx,
  output logic                        win_valid,
  output logic                        win_preempt
);
  logic [NUM_LINES-1:0]        qual;
  logic [PRIO_W*NUM_LINES-1:0] mprio_flat;
  logic                        found;
  logic [IDX_W-1:0]            best_idx;
  prio_t                       best_prio;
  logic                        preempt_c;

  irq_line_qual #(.NUM_LINES(NUM_LINES), .IMPL_BITS(IMPL_BITS)) i_qual (
    .pend(req_pend), .en(req_en), .prio_flat(req_prio),
    .qual(qual), .mprio_flat(mprio_flat)
  );

  irq_pick_min #(.NUM_LINES(NUM_LINES)) i_pick (
    .qual(qual), .mprio_flat(mprio_flat),
    .found(found), .best_idx(best_idx), .best_prio(best_prio)
  );

  irq_preempt_gate #(.IMPL_BITS(IMPL_BITS)) i_gate (
    .found(found), .best_prio(best_prio), .split(grp_split),
    .active(hdl_active), .active_prio(hdl_prio), .preempt(preempt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_idx     <= '0;
      win_valid   <= 1'b0;
      win_preempt <= 1'b0;
    end else begin
      win_idx     <= best_idx;
      win_valid   <= found;
      win_preempt <= preempt_c;
    end
  end

  // R2
  winner_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && win_valid) |-> ((($past(req_pend & req_en)) >> win_idx) & 1) != 0);

  // R2
  none_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !win_valid) |-> ($past(req_pend & req_en) == '0));

  // R7
  preempt_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    win_preempt |-> win_valid);

  // R8
  idle_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hdl_active)) |-> (win_preempt == win_valid));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!win_valid && !win_preempt && win_idx == '0));
endmodule

// File: tb/test_irq_group_arbiter.sv
module test_irq_group_arbiter;
  localparam int N = 8;
  localparam int IB = 4;
  localparam int IW = $clog2(N);
  localparam logic [7:0] MASK = 8'hF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_pend = '0, req_en = '0;
  logic [8*N-1:0] req_prio = '0;
  logic [2:0] grp_split = '0;
  logic hdl_active = 1'b0;
  logic [7:0] hdl_prio = '0;
  logic [IW-1:0] win_idx;
  logic win_valid, win_preempt;
  int total = 0, bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_group_arbiter #(.NUM_LINES(N), .IMPL_BITS(IB)) i_irq_group_arbiter (
    .clk(clk), .rst(rst), .req_pend(req_pend), .req_en(req_en),
    .req_prio(req_prio), .grp_split(grp_split), .hdl_active(hdl_active),
    .hdl_prio(hdl_prio), .win_idx(win_idx), .win_valid(win_valid),
    .win_preempt(win_preempt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model: group compares before subpriority, then index
  task automatic expect_all(input string req);
    int eidx = 0; logic ev = 0; logic ep; logic [7:0] bg = 0, bs = 0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] p, g, s;
      p = req_prio[8*i +: 8] & MASK;
      g = p >> grp_split;
      s = p & ((8'd1 << grp_split) - 8'd1);
      if (req_pend[i] && req_en[i]) begin
        if (!ev || g < bg || (g == bg && s < bs)) begin
          ev = 1; eidx = i; bg = g; bs = s;
        end
      end
    end
    ep = ev && (!hdl_active || bg < ((hdl_prio & MASK) >> grp_split));
    @(negedge clk);   // one rising edge has passed (R9)
    check({req, " valid"}, int'(win_valid), int'(ev));
    if (ev) check({req, " idx"}, int'(win_idx), eidx);
    check({req, " preempt"}, int'(win_preempt), int'(ep));
  endtask

  task automatic setp(input int i, input logic [7:0] v);
    req_prio[8*i +: 8] = v;
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    req_pend = '1; req_en = '1;
    @(negedge clk);
    check("R1 valid in reset", int'(win_valid), 0);
    check("R1 idx in reset", int'(win_idx), 0);
    check("R1 preempt in reset", int'(win_preempt), 0);
    rst = 1'b0;
    req_pend = '0;

    // R2: nothing pending
    expect_all("R2 none");
    // R2: urgent line disabled
    req_prio = {N{8'hF0}}; setp(2, 8'h00); req_pend = 8'b0000_0110; req_en = 8'b0000_0010;
    expect_all("R2 disabled");
    check("R2 disabled idx", int'(win_idx), 1);
    // R3/R4: g=4, same group 0x50, sub 0x?? - bits only implemented [7:4]; use g=2
    grp_split = 3'd6; hdl_active = 1'b1; hdl_prio = 8'h40;
    req_pend = '1; req_en = '1; req_prio = {N{8'hF0}};
    setp(5, 8'h70); setp(3, 8'h50);
    expect_all("R4 sub tie-break");
    check("R4 idx", int'(win_idx), 3);
    check("R7 equal group no preempt", int'(win_preempt), 0);
    // R3: lower group wins regardless of index
    grp_split = 3'd4; setp(6, 8'h20);
    expect_all("R3 group");
    check("R3 idx", int'(win_idx), 6);
    check("R7 strict less preempts", int'(win_preempt), 1);
    // R5/R6: differ only in unimplemented bits
    req_prio = {N{8'hF0}}; setp(4, 8'h3F); setp(1, 8'h32); setp(7, 8'h30);
    grp_split = 3'd0; hdl_active = 1'b0;
    expect_all("R5 R6 tie");
    check("R6 idx", int'(win_idx), 1);
    check("R8 idle preempt", int'(win_preempt), 1);
    // R10: split 7 -> 1-bit group; 0x10 and 0x70 share group 0
    grp_split = 3'd7; hdl_active = 1'b1; hdl_prio = 8'h00;
    req_prio = {N{8'hF0}}; setp(0, 8'h70); setp(2, 8'h10);
    expect_all("R10 split7");
    check("R10 idx", int'(win_idx), 2);
    hdl_prio = 8'h80;
    expect_all("R10 split7 preempt");
    check("R10 preempt", int'(win_preempt), 1);
    // R10: split 0 -> whole prio is group; equal active blocks
    grp_split = 3'd0; hdl_prio = 8'h10;
    expect_all("R10 split0");
    check("R10 split0 no preempt", int'(win_preempt), 0);

    // random
    for (int k = 0; k < 1500; k++) begin
      req_pend = N'($urandom); req_en = N'($urandom);
      for (int i = 0; i < N; i++) setp(i, 8'($urandom));
      grp_split = 3'($urandom); hdl_active = 1'($urandom);
      hdl_prio = 8'($urandom);
      expect_all("R3 R4 R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule